// File: doc/BRIEF.md
# Relational Fuzzy Inference Sequencer

This block runs one inference pass of a decomposed relational fuzzy system whose inputs are crisp singletons. Every single-input, single-output subsystem stores its fuzzy subrelation as a table in external asynchronous memory. Each table is addressed by an 8-bit input coordinate and an 8-bit output coordinate and holds 8-bit membership grades. The inputs are singletons, so each latched crisp input is used directly as the row address of its table. No rules are evaluated, and the length of a pass depends only on the number of inputs, the number of groups and the read wait. It does not depend on how many rules built the tables.

A start pulse latches up to `MAX_K` crisp inputs, the input count K, the group count p and the read wait. The sequencer then sweeps the output coordinate y from 0 to 255. For each y it reads every table of every group, one read at a time. It takes the MIN of the K grades inside a group and the MAX over the p groups. It presents the grade for that y on a valid/ready stream.

Stream rules:
- A sample is transferred on a clock edge where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, the sample and its index are held unchanged and no memory read is issued.
- `out_valid` never drops without a transfer.
- A one-cycle `done` pulse follows the transfer of y = 255.

Top module: `fz_relational_seq`

## Requirements
- R1: After reset, `out_valid`, `done`, `busy` and `mem_rd` are all low.
- R2: When `start` is seen while idle, the sequencer latches `crisp_in`, `num_inputs`, `num_groups` and `read_wait` and raises `busy`. Later changes to these inputs, and `start` pulses while `busy` is high, have no effect on the running pass.
- R3: The read address is `mem_addr = {sel, x, y}`, with `sel` in bits 19:16, x in bits 15:8 and y in bits 7:0. Here sel = g*K + k for group g and input k, and x is crisp input k, taken from `crisp_in[8k+7:8k]`. For each y, reads run with k fastest, then g.
- R4: Each read holds `mem_rd` high with a constant address for `read_wait`+1 cycles. The data is captured on the last of those cycles.
- R5: Within a group, the grades of the K reads are combined with MIN.
- R6: The results of the p groups are combined with MAX to give `out_mu` for that y.
- R7: Every pass emits exactly 256 samples, with `out_y` running 0, 1, …, 255 in order.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_y` and `out_mu` hold their values.
- R9: `done` pulses high for one cycle right after the transfer of y = 255. `busy` is low in that same cycle.
- R10: The MAX accumulator is cleared at the start of each pass and for each output point, so no grade carries over from an earlier point or pass.
- R11: A value of 0 for `num_inputs` or `num_groups` is treated as 1. A `num_inputs` value above `MAX_K` is treated as `MAX_K`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a pass when idle |
| num_inputs | input | 3 | Input count K |
| num_groups | input | 4 | Subsystem group count p |
| read_wait | input | 4 | Extra wait cycles per memory read |
| crisp_in | input | 32 | Crisp inputs, 8 bits each, input 0 lowest |
| mem_addr | output | 20 | Table address {sel, x, y} |
| mem_rd | output | 1 | Memory read enable |
| mem_rdata | input | 8 | Memory read data |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream ready |
| out_y | output | 8 | Output coordinate of the sample |
| out_mu | output | 8 | Output membership grade |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The assertions check several behaviours on every cycle:
- the read address stays steady for the whole wait window;
- a stalled sample holds its value;
- `done` only follows the transfer of y = 255;
- the table select stays inside the K·p range;
- the running MIN never rises inside a group.

Only the bench scenarios can show the arithmetic itself: the MIN/MAX combination against a reference loop over the same tables. The scenarios also show:
- the capture cycle is correct, because the memory model returns corrupted data before its latency has passed;
- input changes and `start` pulses during a pass are ignored;
- the accumulator is cleared between passes;
- zero counts are treated as 1.

// File: rtl/fz_pkg.sv
package fz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EMIT = 2'd2
  } fz_state_t;
endpackage

// File: rtl/fz_read_timer.sv
// Counts the wait cycles of one memory read and fires on its last cycle.
module fz_read_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WAIT_W-1:0] wait_lim,
  output logic              fire
);
  logic [WAIT_W-1:0] cnt;

  assign fire = run && (cnt == wait_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (fire)   cnt <= '0;
    else             cnt <= cnt + WAIT_W'(1);
  end
endmodule

// File: rtl/fz_addr_gen.sv
// Walks the read order: input k fastest, then group g; y advances per emitted sample.
module fz_addr_gen #(
  parameter int K_W   = 3,
  parameter int SEL_W = 4,
  parameter int CO_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             y_step,
  input  logic [K_W-1:0]   k_lim,
  input  logic [SEL_W-1:0] g_lim,
  output logic [K_W-1:0]   k_idx,
  output logic [SEL_W-1:0] sel,
  output logic [CO_W-1:0]  y_idx,
  output logic             last_k,
  output logic             last_g,
  output logic             last_y
);
  logic [SEL_W-1:0] g_idx;

  assign last_k = (k_idx == k_lim - K_W'(1));
  assign last_g = (g_idx == g_lim - SEL_W'(1));
  assign last_y = &y_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_idx <= '0;
      g_idx <= '0;
      sel   <= '0;
    end else if (clr) begin
      k_idx <= '0;
      g_idx <= '0;
      sel   <= '0;
    end else if (step) begin
      if (last_k) begin
        k_idx <= '0;
        if (last_g) begin
          g_idx <= '0;
          sel   <= '0;
        end else begin
          g_idx <= g_idx + SEL_W'(1);
          sel   <= sel + SEL_W'(1);
        end
      end else begin
        k_idx <= k_idx + K_W'(1);
        sel   <= sel + SEL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      y_idx <= '0;
    else if (clr)    y_idx <= '0;
    else if (y_step) y_idx <= y_idx + CO_W'(1);
  end
endmodule

// File: rtl/fz_minmax_acc.sv
// MIN across the inputs of a group, MAX across the groups of one output point.
module fz_minmax_acc #(
  parameter int MU_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            take,
  input  logic            last_k,
  input  logic            last_g,
  input  logic [MU_W-1:0] rdata,
  output logic [MU_W-1:0] mu
);
  logic [MU_W-1:0] min_q, max_q, mn, mx;

  assign mn = (rdata < min_q) ? rdata : min_q;
  assign mx = (mn > max_q) ? mn : max_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '1;
      max_q <= '0;
      mu    <= '0;
    end else if (clr) begin
      min_q <= '1;
      max_q <= '0;
    end else if (take) begin
      if (last_k) begin
        min_q <= '1;
        if (last_g) begin
          max_q <= '0;
          mu    <= mx;
        end else begin
          max_q <= mx;
        end
      end else begin
        min_q <= mn;
      end
    end
  end

  // R5: the running MIN never rises between group boundaries
  assert_min_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(take) && !$past(last_k) && !$past(clr)) |-> (min_q <= $past(min_q)));
endmodule

// File: rtl/fz_relational_seq.sv
module fz_relational_seq #(
  parameter int MU_W   = 8,
  parameter int CO_W   = 8,
  parameter int SEL_W  = 4,
  parameter int MAX_K  = 4,
  parameter int WAIT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [$clog2(MAX_K+1)-1:0] num_inputs,
  input  logic [SEL_W-1:0]      num_groups,
  input  logic [WAIT_W-1:0]     read_wait,
  input  logic [MAX_K*CO_W-1:0] crisp_in,
  output logic [SEL_W+2*CO_W-1:0] mem_addr,
  output logic                  mem_rd,
  input  logic [MU_W-1:0]       mem_rdata,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [CO_W-1:0]       out_y,
  output logic [MU_W-1:0]       out_mu,
  output logic                  busy,
  output logic                  done
);
  import fz_pkg::*;

  localparam int K_W    = $clog2(MAX_K+1);
  localparam int PROD_W = K_W + SEL_W;

  fz_state_t state;
  logic [MAX_K*CO_W-1:0] x_q;
  logic [K_W-1:0]        k_lim_q;
  logic [SEL_W-1:0]      p_q;
  logic [WAIT_W-1:0]     wait_q;
  logic [K_W-1:0]        k_idx;
  logic [SEL_W-1:0]      sel;
  logic [CO_W-1:0]       y_idx;
  logic                  last_k, last_g, last_y;
  logic                  fire, launch, hs;
  logic [K_W-1:0]        k_eff;
  logic [SEL_W-1:0]      p_eff;
  logic [CO_W-1:0]       x_cur;
  logic [PROD_W-1:0]     prod;

  assign launch = (state == ST_IDLE) && start;
  assign hs     = (state == ST_EMIT) && out_ready;

  always_comb begin
    if (num_inputs == '0)                   k_eff = K_W'(1);
    else if (int'(num_inputs) > MAX_K)      k_eff = K_W'(MAX_K);
    else                                    k_eff = num_inputs;
    p_eff = (num_groups == '0) ? SEL_W'(1) : num_groups;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      k_lim_q <= K_W'(1);
      p_q     <= SEL_W'(1);
      wait_q  <= '0;
    end else if (launch) begin
      x_q     <= crisp_in;
      k_lim_q <= k_eff;
      p_q     <= p_eff;
      wait_q  <= read_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) state <= ST_READ;
        ST_READ: if (fire && last_k && last_g) state <= ST_EMIT;
        ST_EMIT: if (out_ready) begin
          if (last_y) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  fz_read_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_READ),
    .wait_lim(wait_q), .fire(fire)
  );

  fz_addr_gen #(.K_W(K_W), .SEL_W(SEL_W), .CO_W(CO_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(launch), .step(fire),
    .y_step(hs && !last_y), .k_lim(k_lim_q), .g_lim(p_q),
    .k_idx(k_idx), .sel(sel), .y_idx(y_idx),
    .last_k(last_k), .last_g(last_g), .last_y(last_y)
  );

  fz_minmax_acc #(.MU_W(MU_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(launch), .take(fire),
    .last_k(last_k), .last_g(last_g), .rdata(mem_rdata), .mu(out_mu)
  );

  assign x_cur     = x_q[k_idx*CO_W +: CO_W];
  assign mem_addr  = {sel, x_cur, y_idx};
  assign mem_rd    = (state == ST_READ);
  assign out_valid = (state == ST_EMIT);
  assign out_y     = y_idx;
  assign busy      = (state != ST_IDLE);
  assign prod      = PROD_W'(k_lim_q) * PROD_W'(p_q);

  // R4: address and read enable steady until the capture cycle
  assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !fire) |=> (mem_rd && $stable(mem_addr)));

  // R8: a stalled sample holds
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y) && $stable(out_mu)));

  // R9: done only after the transfer of the last point
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid && out_ready && (out_y == {CO_W{1'b1}})) && !busy));

  // R3: the table select stays inside the K*p tables of the pass
  assert_sel_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && (prod <= PROD_W'(2**SEL_W))) |-> (PROD_W'(sel) < prod));

  // R2: a start while idle begins a pass
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: tb/sim_fz_relational_seq.sv
module sim_fz_relational_seq;
  localparam int LAT = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [2:0]  num_inputs = 3'd1;
  logic [3:0]  num_groups = 4'd1;
  logic [3:0]  read_wait = 4'd3;
  logic [31:0] crisp_in = '0;
  logic [19:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_y, out_mu;
  logic        busy, done;

  int errors = 0, checks = 0, tick = 0;
  int mode = 0, rdy_mode = 0;
  logic [15:0] exp_q[$];
  int recv = 0;
  bit last_pending = 0, pass_done = 0;
  bit stall_prev = 0;
  logic [7:0] stall_y, stall_mu;

  always #10 clk = ~clk;

  fz_relational_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .num_inputs(num_inputs),
    .num_groups(num_groups), .read_wait(read_wait), .crisp_in(crisp_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y),
    .out_mu(out_mu), .busy(busy), .done(done)
  );

  function automatic logic [7:0] tbl(int s, int x, int y);
    if (mode == 1) return 8'((16 + (s * 3 + x + y) % 16));
    return 8'(((s * 53 + x * 29 + y * 17) ^ ((y * 5) >> 2) ^ (x << 1)) & 255);
  endfunction

  // Memory model: data is corrupted until the address has been held LAT full cycles
  logic [19:0] addr_q = '0;
  int scnt = 0;
  always @(posedge clk) begin
    addr_q <= mem_addr;
    if (mem_addr != addr_q) scnt <= 0;
    else if (scnt < 1000) scnt <= scnt + 1;
  end
  always_comb begin
    int held;
    logic [7:0] v;
    held = (mem_addr == addr_q) ? scnt + 1 : 0;
    v = tbl(int'(mem_addr[19:16]), int'(mem_addr[15:8]), int'(mem_addr[7:0]));
    if (!mem_rd) mem_rdata = 8'h00;
    else if (held >= LAT) mem_rdata = v;
    else mem_rdata = ~v;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: pushes the 256 expected samples of a pass, then starts it
  task automatic run_pass(int k, int p, int w, logic [31:0] xs, bit disturb);
    int ke, pe;
    ke = (k == 0) ? 1 : (k > 4 ? 4 : k);
    pe = (p == 0) ? 1 : p;
    for (int y = 0; y < 256; y++) begin
      int mx;
      mx = 0;
      for (int g = 0; g < pe; g++) begin
        int mn;
        mn = 255;
        for (int i = 0; i < ke; i++) begin
          int v;
          v = int'(tbl(g * ke + i, int'(xs[8*i +: 8]), y));
          if (v < mn) mn = v;
        end
        if (mn > mx) mx = mn;
      end
      exp_q.push_back({8'(y), 8'(mx)});
    end
    @(negedge clk);
    num_inputs = 3'(k); num_groups = 4'(p); read_wait = 4'(w); crisp_in = xs;
    start = 1; pass_done = 0; recv = 0;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (disturb) begin
      repeat (40) @(negedge clk);
      crisp_in = ~xs; num_inputs = 3'd2; num_groups = 4'd7; read_wait = 4'd0;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!pass_done && tick < 190000) @(negedge clk);
    check(recv == 256, "R7 samples per pass", recv, 256);
    check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // Monitor: handshakes are decided at the negedge for the following posedge
  always @(negedge clk) begin
    logic [15:0] e;
    tick++;
    if (rst_n) begin
      if (last_pending) begin
        check(done == 1'b1, "R9 done after last transfer", int'(done), 1);
        check(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
        last_pending = 0;
        pass_done = 1;
      end else if (done) begin
        check(1'b0, "R9 stray done", 1, 0);
      end
      if (stall_prev) begin
        check(out_valid && out_y == stall_y && out_mu == stall_mu,
              "R8 hold under stall", int'(out_mu), int'(stall_mu));
      end
    end
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (tick % 3) != 0;
      default: out_ready = (tick % 7) < 2;
    endcase
    stall_prev = rst_n && out_valid && !out_ready;
    stall_y = out_y;
    stall_mu = out_mu;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected sample", int'(out_y), -1);
      end else begin
        e = exp_q.pop_front();
        check(out_y == e[15:8], "R7 y order", int'(out_y), int'(e[15:8]));
        check(out_mu == e[7:0], "R5 R6 MIN/MAX grade", int'(out_mu), int'(e[7:0]));
        recv++;
        if (out_y == 8'hFF) last_pending = 1;
      end
    end
  end

  // Watchdog
  always @(negedge clk) begin
    if (tick > 195000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick, 195000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && !done && !busy && !mem_rd, "R1 reset state",
          int'({out_valid, done, busy, mem_rd}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R3 R4 R5: K=2, p=1, exact latency
    run_pass(2, 1, LAT, 32'h0000_5A13, 0);
    // R6 R8: K=2, p=3, stalling downstream
    rdy_mode = 1;
    run_pass(2, 3, LAT, 32'h0000_C807, 0);
    // R2: inputs changed and start pulsed mid-pass; K=4, p=4, longer wait
    rdy_mode = 2;
    run_pass(4, 4, LAT + 2, 32'h11F0_3C99, 1);
    // R10: low-valued tables after a high-valued pass; accumulator must not leak
    rdy_mode = 0;
    mode = 1;
    run_pass(3, 2, LAT, 32'h0004_2A61, 0);
    // R11: zero counts behave as one
    mode = 0;
    run_pass(0, 0, LAT, 32'h0000_0077, 0);
    repeat (5) @(negedge clk);
    check(!out_valid && !busy, "R1 idle after passes", int'({out_valid, busy}), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule